// File: doc/BRIEF.md
# Background Flash CRC Scanner

This block checks the integrity of a region of flash-style memory while the rest of the system keeps running. Software supplies a byte start address, a length in bytes, a wait-state count, a period and an auto-repeat flag, then pulses start. The engine reads the region one whole memory word at a time over a request/grant port. That port has the lowest priority, so a read is granted only on a cycle in which no other master wants the memory. The engine then folds the bytes of each word into a CRC-32, one byte per clock. Neither the start address nor the length has to fall on a word boundary.

At the end of each pass the engine pulses `done` and updates `crc_out`. With auto-repeat set, it waits a programmable gap and then scans the region again without software help. The gap is counted in ticks of a slow fixed-rate period clock, which arrives as a one-cycle enable on `per_tick`. This keeps the scanner's share of memory bandwidth under software control.

Top module: `fcrc_scanner`

## Requirements
- R1: The result is CRC-32 with the reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and output XOR 0xFFFFFFFF. The nine ASCII bytes "123456789" give 0xCBF43926.
- R2: Only the bytes from the start address up to start+length-1 are folded in, in ascending address order, whatever the alignment of the start address and the length. Byte k of a memory word sits at `mem_rdata[8k+7:8k]`.
- R3: A pass issues exactly one granted read for each memory word the region touches, which is floor((start+len-1)/W) - floor(start/W) + 1 reads for word size W.
- R4: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_gnt` is seen. While the grant is withheld the pass makes no progress and does not finish.
- R5: After a grant, the read data is taken from `mem_rdata` exactly `cfg_wait`+1 cycles later. `cfg_wait` is sampled when the pass launches.
- R6: `done` is high for exactly one cycle at the end of each pass. `crc_out` changes only on the edge that raises `done` and holds its value otherwise. `crc_out` is 0 after reset.
- R7: A length of zero ends the pass in the cycle after the launch, with no reads. The result is 0x00000000, which is the seed after the output XOR.
- R8: A start pulse while `busy` is high is ignored and does not change the pass in progress.
- R9: With `cfg_auto` low at the end of a pass, the engine returns to idle: `busy` and `mem_req` stay low and no further `done` occurs.
- R10: With `cfg_auto` high at the end of a pass, a new pass starts by itself once the gap has elapsed. With a period of 0, `mem_req` rises 1 cycle after `done` rises. With a period P>0 and `per_tick` held high, `mem_req` rises P+3 cycles after `done`, because the gap adds two bus cycles before the P ticks.
- R11: During the gap, the period count advances only in cycles where `per_tick` is high, and only after the two overhead cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Byte address of the first message byte |
| cfg_len | input | LEN_W | Message length in bytes |
| cfg_wait | input | WS_W | Wait-state count of the memory |
| cfg_period | input | PER_W | Gap between passes, in period-clock ticks |
| cfg_auto | input | 1 | Start a new pass by itself after each gap |
| start | input | 1 | One-cycle pulse that launches a pass when idle |
| per_tick | input | 1 | One-cycle enable from the slow period clock |
| mem_req | output | 1 | Read request to the memory arbiter |
| mem_addr | output | ADDR_W-log2(WORD_BYTES) | Word address of the request |
| mem_gnt | input | 1 | Grant; high only when no other master uses the memory |
| mem_rdata | input | WORD_BYTES*8 | Read data word, byte k in bits 8k+7:8k |
| busy | output | 1 | A pass or a gap is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| crc_out | output | 32 | CRC of the last completed pass |

## Verification
The bench builds the scanner with 16-byte words, a 10-bit byte address and a 12-bit length. Its 1 KiB memory image then holds only 64 words, so short regions cross word boundaries at both ends and the read count per pass can be checked exactly. A 4-bit wait-state field allows a wait count of 7. The modelled memory returns a garbage pattern until the wait states have elapsed, so taking the data a cycle early corrupts the CRC. The competing master can withhold the grant for long stretches or on a repeating pattern.

// File: rtl/fcrc_pkg.sv
// Package fcrc_pkg
// Shared state type and CRC-32 constants for the flash CRC scanner.
// Assumes reflected (LSB-first) CRC-32 processing of whole bytes.
package fcrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } scan_state_t;

    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_XOROUT = 32'hFFFFFFFF;

    // Fold one byte into a reflected CRC-32 state.
    function automatic logic [31:0] crc32_byte(input logic [31:0] state,
                                               input logic [7:0]  data);
        logic [31:0] r;
        r = state ^ {24'h0, data};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcrc_word_fetch.sv
// Module fcrc_word_fetch
// Issues one lowest-priority word read per go pulse. The request is held
// until granted, the wait-state count is then spent, and the data word is
// captured and kept in word_q until the next capture.
// Assumes: go arrives only while idle; mem_gnt is high only when the
// arbiter has no higher-priority master.
module fcrc_word_fetch #(
    parameter int WORD_BYTES = 32,
    parameter int WADDR_W    = 11,
    parameter int WS_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [WADDR_W-1:0]      go_addr,
    input  logic [WS_W-1:0]         wait_cycles,
    output logic                    mem_req,
    output logic [WADDR_W-1:0]      mem_addr,
    input  logic                    mem_gnt,
    input  logic [WORD_BYTES*8-1:0] mem_rdata,
    output logic                    word_ready,
    output logic [WORD_BYTES*8-1:0] word_q
);

    localparam int WORD_W = WORD_BYTES * 8;

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_phase_t;

    fetch_phase_t        phase;
    logic [WADDR_W-1:0]  addr_q;
    logic [WS_W-1:0]     wait_cnt;

    // Request / wait / capture sequencer for a single word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= F_IDLE;
            addr_q     <= '0;
            wait_cnt   <= '0;
            word_ready <= 1'b0;
            word_q     <= '0;
        end else begin
            word_ready <= 1'b0;
            case (phase)
                F_IDLE: begin
                    if (go) begin
                        addr_q <= go_addr;
                        phase  <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (mem_gnt) begin
                        wait_cnt <= wait_cycles;
                        phase    <= F_WAIT;
                    end
                end
                F_WAIT: begin
                    if (wait_cnt == '0) begin
                        word_q     <= WORD_W'(mem_rdata);
                        word_ready <= 1'b1;
                        phase      <= F_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: phase <= F_IDLE;
            endcase
        end
    end

    // Drive the arbiter port from the sequencer state.
    always_comb begin
        mem_req  = (phase == F_REQ);
        mem_addr = addr_q;
    end

    // R4: an ungranted request is kept up with the same address.
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R5: data is never ready in the cycle right after a grant.
    a_r5_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !word_ready);

endmodule

// File: rtl/fcrc_byte_crc.sv
// Module fcrc_byte_crc
// Holds the running CRC-32 and folds in one byte per enabled cycle. The
// byte is picked from the captured word by its offset within the word.
// Assumes: init and en are never both relevant (init wins).
module fcrc_byte_crc #(
    parameter int WORD_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          init,
    input  logic                          en,
    input  logic [WORD_BYTES*8-1:0]       word,
    input  logic [$clog2(WORD_BYTES)-1:0] sel,
    output logic [31:0]                   crc_q,
    output logic [31:0]                   crc_next
);

    import fcrc_pkg::*;

    logic [7:0] cur_byte;

    // Pick the byte at the current offset and compute the next CRC.
    always_comb begin
        cur_byte = word[{sel, 3'b000} +: 8];
        crc_next = crc32_byte(crc_q, cur_byte);
    end

    // Running CRC register: seed on init, advance on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (init) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/fcrc_gap_timer.sv
// Module fcrc_gap_timer
// Times the pause between passes: a fixed number of bus-cycle overhead
// cycles (only when the period is nonzero), then the period in slow ticks.
// Assumes: tick is a one-cycle enable synchronous to clk.
module fcrc_gap_timer #(
    parameter int PER_W      = 12,
    parameter int OVH_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] period,
    input  logic             tick,
    output logic             expired
);

    localparam int OVH_W = $clog2(OVH_CYCLES + 1);

    logic [OVH_W-1:0] ovh_cnt;
    logic [PER_W-1:0] tick_cnt;

    // Gap counters: overhead cycles first, then period ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovh_cnt  <= '0;
            tick_cnt <= '0;
        end else if (load) begin
            ovh_cnt  <= (period != '0) ? OVH_W'(OVH_CYCLES) : '0;
            tick_cnt <= period;
        end else if (ovh_cnt != '0) begin
            ovh_cnt <= ovh_cnt - 1'b1;
        end else if (tick && (tick_cnt != '0)) begin
            tick_cnt <= tick_cnt - 1'b1;
        end
    end

    // The gap is over once both counters have drained.
    always_comb begin
        expired = (ovh_cnt == '0) && (tick_cnt == '0);
    end

    // R11: the period count moves only on a tick after the overhead.
    a_r11_ticks_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (!tick || ovh_cnt != '0)) |=> $stable(tick_cnt));

endmodule

// File: rtl/fcrc_scanner.sv
// Module fcrc_scanner (top)
// Background CRC-32 scanner over a byte-addressed region of a wide memory.
// Launch sequence: sample the configuration, fetch the word that holds the
// first byte, fold in bytes one per clock, fetch the next word at each word
// end, and finish on the last byte. With auto-repeat set it then waits the
// gap and launches again.
// Assumes: the configuration inputs hold steady while a launch is sampled;
// WORD_BYTES is a power of two (16 or 32 in practice).
module fcrc_scanner #(
    parameter int WORD_BYTES = 32,
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int WS_W       = 4,
    parameter int PER_W      = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [ADDR_W-1:0]                        cfg_base,
    input  logic [LEN_W-1:0]                         cfg_len,
    input  logic [WS_W-1:0]                          cfg_wait,
    input  logic [PER_W-1:0]                         cfg_period,
    input  logic                                     cfg_auto,
    input  logic                                     start,
    input  logic                                     per_tick,
    output logic                                     mem_req,
    output logic [ADDR_W-$clog2(WORD_BYTES)-1:0]     mem_addr,
    input  logic                                     mem_gnt,
    input  logic [WORD_BYTES*8-1:0]                  mem_rdata,
    output logic                                     busy,
    output logic                                     done,
    output logic [31:0]                              crc_out
);

    import fcrc_pkg::*;

    localparam int OFS_W   = $clog2(WORD_BYTES);
    localparam int WADDR_W = ADDR_W - OFS_W;
    localparam int WORD_W  = WORD_BYTES * 8;

    scan_state_t         state;
    logic [WADDR_W-1:0]  cur_word;
    logic [OFS_W-1:0]    idx;
    logic [LEN_W-1:0]    remaining;
    logic [WS_W-1:0]     wait_q;
    logic                done_q;
    logic [31:0]         crc_out_q;

    logic                launch;
    logic                last_byte;
    logic                word_end;
    logic                fetch_go;
    logic [WADDR_W-1:0]  fetch_addr;
    logic                pass_end;
    logic                gap_load;
    logic                gap_expired;
    logic                word_ready;
    logic [WORD_W-1:0]   word_q;
    logic [31:0]         crc_q;
    logic [31:0]         crc_next;
    logic [31:0]         result;

    // Control decode for the current cycle.
    always_comb begin
        launch     = ((state == ST_IDLE) && start) ||
                     ((state == ST_GAP) && gap_expired);
        last_byte  = (state == ST_SHIFT) && (remaining == LEN_W'(1));
        word_end   = (state == ST_SHIFT) && (idx == {OFS_W{1'b1}});
        fetch_go   = (launch && (cfg_len != '0)) ||
                     (word_end && !last_byte);
        fetch_addr = launch ? cfg_base[ADDR_W-1:OFS_W]
                            : WADDR_W'(cur_word + 1'b1);
        pass_end   = (launch && (cfg_len == '0)) || last_byte;
        gap_load   = pass_end && cfg_auto;
        result     = last_byte ? (crc_next ^ CRC_XOROUT)
                               : (CRC_SEED ^ CRC_XOROUT);
    end

    // Pass sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE, ST_GAP: begin
                    if (launch) begin
                        if (cfg_len == '0) begin
                            state <= cfg_auto ? ST_GAP : ST_IDLE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (word_ready) begin
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_byte) begin
                        state <= cfg_auto ? ST_GAP : ST_IDLE;
                    end else if (word_end) begin
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Message position: word address, byte offset and bytes left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word  <= '0;
            idx       <= '0;
            remaining <= '0;
            wait_q    <= '0;
        end else if (launch) begin
            cur_word  <= cfg_base[ADDR_W-1:OFS_W];
            idx       <= cfg_base[OFS_W-1:0];
            remaining <= cfg_len;
            wait_q    <= cfg_wait;
        end else if (state == ST_SHIFT) begin
            idx       <= idx + 1'b1;
            remaining <= remaining - 1'b1;
            if (word_end) begin
                cur_word <= WADDR_W'(cur_word + 1'b1);
            end
        end
    end

    // Completion pulse and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            crc_out_q <= '0;
        end else begin
            done_q <= pass_end;
            if (pass_end) begin
                crc_out_q <= result;
            end
        end
    end

    // Output drive.
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = done_q;
        crc_out = crc_out_q;
    end

    fcrc_word_fetch #(
        .WORD_BYTES (WORD_BYTES),
        .WADDR_W    (WADDR_W),
        .WS_W       (WS_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (fetch_go),
        .go_addr     (fetch_addr),
        .wait_cycles (wait_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .word_ready  (word_ready),
        .word_q      (word_q)
    );

    fcrc_byte_crc #(
        .WORD_BYTES (WORD_BYTES)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (launch),
        .en       (state == ST_SHIFT),
        .word     (word_q),
        .sel      (idx),
        .crc_q    (crc_q),
        .crc_next (crc_next)
    );

    fcrc_gap_timer #(
        .PER_W      (PER_W),
        .OVH_CYCLES (2)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .period  (cfg_period),
        .tick    (per_tick),
        .expired (gap_expired)
    );

    // R6: the completion pulse never lasts two cycles.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the result only moves together with the completion pulse.
    a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(crc_out));

    // R9: an idle engine places no request on the memory port.
    a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R2: bytes are only folded while some remain in the message.
    a_r2_shift_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (remaining != '0));

endmodule

// File: tb/fcrc_scanner_bench.sv
// Directed bench for fcrc_scanner: behavioural memory with wait states
// and a competing higher-priority master, one task per scenario.
module fcrc_scanner_bench;

    localparam int WB     = 16;
    localparam int ADDR_W = 10;
    localparam int LEN_W  = 12;
    localparam int WS_W   = 4;
    localparam int PER_W  = 12;
    localparam int OFS_W  = $clog2(WB);
    localparam int MEM_N  = 1 << ADDR_W;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [ADDR_W-1:0]         cfg_base = '0;
    logic [LEN_W-1:0]          cfg_len = '0;
    logic [WS_W-1:0]           cfg_wait = '0;
    logic [PER_W-1:0]          cfg_period = '0;
    logic                      cfg_auto = 1'b0;
    logic                      start = 1'b0;
    logic                      per_tick = 1'b0;
    logic                      mem_req;
    logic [ADDR_W-OFS_W-1:0]   mem_addr;
    logic                      mem_gnt;
    logic [WB*8-1:0]           mem_rdata;
    logic                      busy;
    logic                      done;
    logic [31:0]               crc_out;

    logic [7:0] mem_b [0:MEM_N-1];
    logic       hi_force = 1'b0;
    logic       hi_mode  = 1'b0;
    logic [2:0] hi_pat   = '0;
    logic       hi_req;
    int         lat_word = 0;
    int         age = 0;
    int         rd_cnt = 0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    fcrc_scanner #(
        .WORD_BYTES (WB),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .WS_W       (WS_W),
        .PER_W      (PER_W)
    ) u_fcrc_scanner (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_base   (cfg_base),
        .cfg_len    (cfg_len),
        .cfg_wait   (cfg_wait),
        .cfg_period (cfg_period),
        .cfg_auto   (cfg_auto),
        .start      (start),
        .per_tick   (per_tick),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .crc_out    (crc_out)
    );

    // Competing master and lowest-priority arbitration.
    always @(negedge clk) hi_pat <= hi_pat + 3'd1;
    assign hi_req  = hi_force | (hi_mode & (hi_pat != 3'd0));
    assign mem_gnt = mem_req & ~hi_req;

    // Memory model: latch the granted word, count cycles since the grant.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            lat_word <= int'(mem_addr);
            age      <= 0;
            rd_cnt   <= rd_cnt + 1;
        end else if (age < 1000) begin
            age <= age + 1;
        end
    end

    // Data is valid only once the wait states have elapsed.
    always_comb begin
        for (int j = 0; j < WB; j++) begin
            mem_rdata[j*8 +: 8] = (age >= int'(cfg_wait)) ?
                mem_b[lat_word*WB + j] : (8'hA5 ^ 8'(j));
        end
    end

    function automatic logic [31:0] ref_crc(input int base, input int len);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ mem_b[base + i][k];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    function automatic int exp_reads(input int base, input int len);
        return ((base + len - 1) / WB) - (base / WB) + 1;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Wait for done (checked at a negedge); counts a timeout as a failure.
    task automatic wait_done(input string req, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!seen) chk(1'b0, {req, " done timeout"}, 32'd0, 32'd1);
    endtask

    task automatic set_cfg(input int base, input int len, input int w);
        cfg_base = ADDR_W'(base);
        cfg_len  = LEN_W'(len);
        cfg_wait = WS_W'(w);
    endtask

    // One full pass with result and read-count checks.
    task automatic run_pass(input string req, input int base, input int len,
                            input int w);
        int r0;
        bit seen;
        set_cfg(base, len, w);
        r0 = rd_cnt;
        pulse_start();
        wait_done(req, seen);
        if (seen) begin
            chk(crc_out == ref_crc(base, len), {req, " crc"},
                crc_out, ref_crc(base, len));
            @(negedge clk);
            chk(!done, {"R6 done one cycle (", req, ")"}, 32'(done), 32'd0);
            chk(rd_cnt - r0 == exp_reads(base, len), {"R3 reads (", req, ")"},
                32'(rd_cnt - r0), 32'(exp_reads(base, len)));
        end
    endtask

    task automatic t_reset();
        chk(!done && !busy && !mem_req, "R6 reset outputs quiet",
            {29'd0, done, busy, mem_req}, 32'd0);
        chk(crc_out == 32'd0, "R6 reset crc_out", crc_out, 32'd0);
    endtask

    task automatic t_known_vector();
        bit seen;
        set_cfg(110, 9, 1);
        pulse_start();
        wait_done("R1", seen);
        chk(crc_out == 32'hCBF43926, "R1 check string", crc_out, 32'hCBF43926);
        @(negedge clk);
    endtask

    task automatic t_alignment();
        run_pass("R2 aligned words", 32, 64, 2);
        run_pass("R2 unaligned both ends", 14, 20, 1);
        run_pass("R2 single last byte", 15, 1, 0);
        run_pass("R2 long unaligned", 201, 333, 3);
    endtask

    task automatic t_wait_states();
        run_pass("R5 wait 7", 9, 40, 7);
        run_pass("R5 wait 0", 0, 16, 0);
    endtask

    task automatic t_zero_len();
        int r0;
        run_pass("R7 prior pass", 64, 5, 1);
        set_cfg(300, 0, 2);
        r0 = rd_cnt;
        pulse_start();
        chk(done == 1'b1, "R7 done in cycle after launch", 32'(done), 32'd1);
        chk(crc_out == 32'h00000000, "R7 empty result", crc_out, 32'd0);
        repeat (3) @(negedge clk);
        chk(rd_cnt == r0, "R7 no reads", 32'(rd_cnt - r0), 32'd0);
    endtask

    task automatic t_contention();
        bit stuck_ok;
        bit seen;
        stuck_ok = 1'b1;
        hi_force = 1'b1;
        set_cfg(3, 100, 2);
        pulse_start();
        repeat (50) begin
            @(negedge clk);
            if (!mem_req || done) stuck_ok = 1'b0;
        end
        chk(stuck_ok, "R4 no progress without grant", 32'(stuck_ok), 32'd1);
        hi_force = 1'b0;
        hi_mode  = 1'b1;
        wait_done("R4", seen);
        chk(crc_out == ref_crc(3, 100), "R4 crc under contention",
            crc_out, ref_crc(3, 100));
        hi_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        bit quiet;
        bit seen;
        quiet = 1'b1;
        set_cfg(0, 200, 2);
        pulse_start();
        repeat (20) @(negedge clk);
        set_cfg(500, 3, 0);
        pulse_start();
        wait_done("R8", seen);
        chk(crc_out == ref_crc(0, 200), "R8 start while busy ignored",
            crc_out, ref_crc(0, 200));
        repeat (40) begin
            @(negedge clk);
            if (done || busy || mem_req) quiet = 1'b0;
        end
        chk(quiet, "R9 stays idle without auto", 32'(quiet), 32'd1);
    endtask

    task automatic t_gap(input int p);
        int  n;
        bit  seen;
        logic [31:0] first;
        per_tick   = 1'b1;
        cfg_period = PER_W'(p);
        cfg_auto   = 1'b1;
        set_cfg(40, 8, 1);
        pulse_start();
        wait_done("R10", seen);
        first = crc_out;
        n = 0;
        while (!mem_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == ((p == 0) ? 1 : p + 3), "R10 restart delay",
            32'(n), 32'((p == 0) ? 1 : p + 3));
        cfg_auto = 1'b0;
        @(negedge clk);
        wait_done("R10", seen);
        chk(crc_out == first && seen, "R10 repeated pass result", crc_out, first);
        repeat (3) @(negedge clk);
        chk(!busy, "R9 auto cleared ends repeat", 32'(busy), 32'd0);
        per_tick = 1'b0;
    endtask

    task automatic t_sparse_ticks();
        bit early;
        bit seen;
        early      = 1'b0;
        per_tick   = 1'b0;
        cfg_period = PER_W'(3);
        cfg_auto   = 1'b1;
        set_cfg(77, 30, 0);
        pulse_start();
        wait_done("R11", seen);
        for (int t = 0; t < 3; t++) begin
            repeat (9) begin
                @(negedge clk);
                if (mem_req) early = 1'b1;
            end
            per_tick = 1'b1;
            @(negedge clk);
            per_tick = 1'b0;
            if (mem_req) early = 1'b1;
        end
        chk(!early, "R11 no restart before third tick", 32'(early), 32'd0);
        @(negedge clk);
        chk(mem_req, "R11 restart after third tick", 32'(mem_req), 32'd1);
        cfg_auto = 1'b0;
        wait_done("R11", seen);
        chk(crc_out == ref_crc(77, 30), "R11 second pass crc",
            crc_out, ref_crc(77, 30));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            mem_b[i] = 8'(i * 29 + (i >> 4) + 7);
        end
        for (int k = 0; k < 9; k++) begin
            mem_b[110 + k] = 8'(8'h31 + k);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_vector();
        t_alignment();
        t_wait_states();
        t_zero_len();
        t_contention();
        t_busy_ignore();
        t_gap(0);
        t_gap(5);
        t_sparse_ticks();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R6 watchdog: actual %0d cycles expected fewer", 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule